// File: doc/BRIEF.md
# Split-Aware Priority Bus Arbiter

This block decides which of several masters owns a shared pipelined bus. Each master raises a request line and, when it needs an uninterrupted sequence, a lock line. The arbiter drives a one-hot grant vector. It also drives the number of the master that owns the current address phase, and a flag that marks that address phase as part of a locked sequence. Index 0 is a dummy master whose bus outputs are tied to IDLE. The arbiter grants it when no real master may safely own the bus.

Slaves can answer a transfer with a two-cycle SPLIT response. When that happens, the arbiter takes the owner of that data phase out of arbitration. It keeps that master out until the slave pulses the matching bit of the release vector. The arbiter counts beats of defined-length bursts so that those bursts are not interrupted. It holds the grant across a locked sequence and for one unlocked transfer after it. It keeps a locked master granted when that master is told to RETRY. When nobody asks for the bus, the grant rests on a chosen default master.

Top module: `split_arbiter`

## Requirements
- R1: While rst_ni is low, grant_o is one-hot on DEFAULT_MASTER (index 1 by default), master_o equals DEFAULT_MASTER and mastlock_o is 0.
- R2: When no hold condition applies, the grant goes to the lowest-indexed requesting real master (index 1 upwards) that is not split-masked. A request on bit 0 is never honoured.
- R3: If no unmasked real master requests, the grant parks on DEFAULT_MASTER, or on the dummy master if DEFAULT_MASTER is split-masked.
- R4: master_o and mastlock_o change only at a clock edge where ready_i is 1. At such an edge master_o takes the index of the master granted before the edge, and mastlock_o takes that master's lock_i bit.
- R5: A SPLIT response (resp_i = 2'b11 with ready_i = 0) masks the master that owns the current data phase. That master is not granted again, even as the only requester, until it is released.
- R6: A single-cycle pulse on release_i bit k unmasks master k, and the release takes effect on the grant decided in that same cycle.
- R7: A SPLIT response to a data phase whose address phase had mastlock_o = 1 grants the dummy master (grant_o = 1) at the next edge.
- R8: When every real master is split-masked, the dummy master is granted.
- R9: The grant stays with its owner while that owner's lock_i bit is 1 or mastlock_o is 1. This yields one extra transfer with mastlock_o = 0 after the lock drops.
- R10: A RETRY response (resp_i = 2'b10 with ready_i = 0) to a locked data phase keeps that data-phase master granted at the next edge.
- R11: A NONSEQ (trans_i = 2'b10) accepted with ready_i = 1 and burst_i of WRAP4/INCR4 (3'b010/3'b011), WRAP8/INCR8 (3'b100/3'b101) or WRAP16/INCR16 (3'b110/3'b111) loads beats-1. Each accepted SEQ (2'b11) counts one beat down, and the grant is held while the count is nonzero. INCR (3'b001) holds nothing, and any non-OKAY response clears the count.
- R12: grant_o has exactly one bit set at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | N_MASTERS | Per-master bus request |
| lock_i | input | N_MASTERS | Per-master lock request |
| ready_i | input | 1 | Global transfer-done signal |
| resp_i | input | 2 | Response: 0 OKAY, 1 ERROR, 2 RETRY, 3 SPLIT |
| trans_i | input | 2 | Transfer type: 0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ |
| burst_i | input | 3 | Burst type of the current address phase |
| release_i | input | N_MASTERS | Split release pulses from slaves |
| grant_o | output | N_MASTERS | One-hot grant |
| master_o | output | $clog2(N_MASTERS) | Owner of the current address phase |
| mastlock_o | output | 1 | Current address phase is locked |

## Verification
A wrong split mask shows up at the first grant decision that involves the affected master. A masked master is granted although it should be excluded, or a released master is passed over, in the cycle of the release pulse. A stale beat count or lock-tail state shows up as a grant that moves to a lower-indexed requester one cycle too early, or stays one cycle too long. Each scenario therefore sets up a contender with higher priority, so that a wrong hold is visible at once at grant_o. A wrong data-phase owner shows up on the next SPLIT or RETRY, because the grant then lands on the wrong index or fails to go to the dummy master.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {RESP_OKAY = 2'd0, RESP_ERROR = 2'd1, RESP_RETRY = 2'd2, RESP_SPLIT = 2'd3} resp_e;
  typedef enum logic [1:0] {TR_IDLE = 2'd0, TR_BUSY = 2'd1, TR_NONSEQ = 2'd2, TR_SEQ = 2'd3} trans_e;
  typedef enum logic [2:0] {
    BU_SINGLE = 3'd0, BU_INCR = 3'd1, BU_WRAP4 = 3'd2, BU_INCR4 = 3'd3,
    BU_WRAP8 = 3'd4, BU_INCR8 = 3'd5, BU_WRAP16 = 3'd6, BU_INCR16 = 3'd7
  } burst_e;

  // beats of a defined-length burst, 0 for open-ended kinds
  function automatic int unsigned burst_beats(logic [2:0] b);
    case (b)
      BU_WRAP4, BU_INCR4:   return 4;
      BU_WRAP8, BU_INCR8:   return 8;
      BU_WRAP16, BU_INCR16: return 16;
      default:              return 0;
    endcase
  endfunction
endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] cand_i,
  output logic [N-1:0] pick_o,
  output logic         any_o
);
  always_comb begin
    pick_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        pick_o    = '0;
        pick_o[i] = 1'b1;
      end
    end
  end
  assign any_o = |cand_i;
endmodule

// File: rtl/arb_split_mask.sv
module arb_split_mask #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] release_i,
  output logic [N-1:0] mask_nxt_o
);
  logic [N-1:0] mask_q;

  // set wins over a simultaneous release; dummy slot never masked
  always_comb begin
    mask_nxt_o    = (mask_q & ~release_i) | set_i;
    mask_nxt_o[0] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_nxt_o;
  end
endmodule

// File: rtl/arb_burst_track.sv
module arb_burst_track #(
  parameter int unsigned CNT_W = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ready_i,
  input  logic [1:0] resp_i,
  input  logic [1:0] trans_i,
  input  logic [2:0] burst_i,
  output logic       active_o
);
  import arb_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  int unsigned      beats;

  assign beats    = burst_beats(burst_i);
  assign active_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (resp_i != RESP_OKAY) begin
      cnt_q <= '0;
    end else if (ready_i) begin
      if (trans_i == TR_NONSEQ)
        cnt_q <= (beats != 0) ? CNT_W'(beats - 1) : '0;
      else if (trans_i == TR_SEQ && cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/split_arbiter.sv
module split_arbiter #(
  parameter int unsigned N_MASTERS      = 5,
  parameter int unsigned DEFAULT_MASTER = 1,
  parameter int unsigned MAX_BEATS      = 16,
  localparam int unsigned MW            = $clog2(N_MASTERS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_MASTERS-1:0] req_i,
  input  logic [N_MASTERS-1:0] lock_i,
  input  logic                 ready_i,
  input  logic [1:0]           resp_i,
  input  logic [1:0]           trans_i,
  input  logic [2:0]           burst_i,
  input  logic [N_MASTERS-1:0] release_i,
  output logic [N_MASTERS-1:0] grant_o,
  output logic [MW-1:0]        master_o,
  output logic                 mastlock_o
);
  import arb_pkg::*;

  localparam int unsigned    CNT_W  = $clog2(MAX_BEATS);
  localparam logic [N_MASTERS-1:0] DEF_OH = N_MASTERS'(1) << DEFAULT_MASTER;
  localparam logic [N_MASTERS-1:0] DUM_OH = N_MASTERS'(1);

  logic [N_MASTERS-1:0] grant_q, grant_d;
  logic [MW-1:0]        master_q, dmaster_q, gidx;
  logic                 mastlock_q, dlocked_q;
  logic [N_MASTERS-1:0] split_set, mask_nxt, cand, pick;
  logic                 any_cand, burst_hold, split_evt, retry_lock, hold;

  always_comb begin
    gidx = '0;
    for (int i = 0; i < N_MASTERS; i++)
      if (grant_q[i]) gidx = MW'(i);
  end

  // first cycle of a two-cycle response
  assign split_evt  = !ready_i && resp_i == RESP_SPLIT && dmaster_q != '0;
  assign retry_lock = !ready_i && resp_i == RESP_RETRY && dlocked_q;
  assign split_set  = split_evt ? (N_MASTERS'(1) << dmaster_q) : '0;

  arb_split_mask #(.N(N_MASTERS)) u_mask (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (split_set),
    .release_i (release_i),
    .mask_nxt_o(mask_nxt)
  );

  arb_burst_track #(.CNT_W(CNT_W)) u_burst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ready_i (ready_i),
    .resp_i  (resp_i),
    .trans_i (trans_i),
    .burst_i (burst_i),
    .active_o(burst_hold)
  );

  assign cand = req_i & ~mask_nxt & ~DUM_OH;

  arb_prio_pick #(.N(N_MASTERS)) u_pick (
    .cand_i(cand),
    .pick_o(pick),
    .any_o (any_cand)
  );

  assign hold = (gidx != '0) && !mask_nxt[gidx] &&
                (lock_i[gidx] || mastlock_q || burst_hold);

  always_comb begin
    if (split_evt && dlocked_q)     grant_d = DUM_OH;
    else if (retry_lock)            grant_d = N_MASTERS'(1) << dmaster_q;
    else if (hold)                  grant_d = grant_q;
    else if (any_cand)              grant_d = pick;
    else if (!mask_nxt[DEFAULT_MASTER]) grant_d = DEF_OH;
    else                            grant_d = DUM_OH;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q    <= DEF_OH;
      master_q   <= MW'(DEFAULT_MASTER);
      mastlock_q <= 1'b0;
      dmaster_q  <= '0;
      dlocked_q  <= 1'b0;
    end else begin
      grant_q <= grant_d;
      if (ready_i) begin
        master_q   <= gidx;
        mastlock_q <= lock_i[gidx];
        dmaster_q  <= master_q;
        dlocked_q  <= mastlock_q;
      end
    end
  end

  assign grant_o    = grant_q;
  assign master_o   = master_q;
  assign mastlock_o = mastlock_q;
endmodule

// File: rtl/split_arbiter_chk.sv
module split_arbiter_chk #(
  parameter int unsigned N_MASTERS = 5,
  parameter int unsigned MW        = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [N_MASTERS-1:0] lock_i,
  input logic                 ready_i,
  input logic [1:0]           resp_i,
  input logic [N_MASTERS-1:0] grant_o,
  input logic [MW-1:0]        master_o,
  input logic                 mastlock_o
);
  logic [MW-1:0] gidx_c, dm_q;
  logic          dl_q;

  always_comb begin
    gidx_c = '0;
    for (int i = 0; i < N_MASTERS; i++)
      if (grant_o[i]) gidx_c = MW'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dm_q <= '0;
      dl_q <= 1'b0;
    end else if (ready_i) begin
      dm_q <= master_o;
      dl_q <= mastlock_o;
    end
  end

  assert_grant_onehot_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(grant_o) == 1);

  assert_owner_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> $stable(master_o) && $stable(mastlock_o));

  assert_owner_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |=> master_o == $past(gidx_c) && mastlock_o == $past(lock_i[gidx_c]));

  assert_locked_split_dummy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_i && resp_i == 2'b11 && dl_q && dm_q != '0) |=> grant_o == N_MASTERS'(1));

  assert_locked_retry_keep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_i && resp_i == 2'b10 && dl_q) |=> grant_o == (N_MASTERS'(1) << $past(dm_q)));
endmodule

bind split_arbiter split_arbiter_chk #(.N_MASTERS(N_MASTERS), .MW(MW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .lock_i    (lock_i),
  .ready_i   (ready_i),
  .resp_i    (resp_i),
  .grant_o   (grant_o),
  .master_o  (master_o),
  .mastlock_o(mastlock_o)
);

// File: tb/split_arbiter_bench.sv
module split_arbiter_bench;
  localparam int N = 5;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req, lock, rel;
  logic         ready;
  logic [1:0]   resp, trans;
  logic [2:0]   burst;
  logic [N-1:0] grant;
  logic [2:0]   master;
  logic         mlock;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  split_arbiter u_split_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .lock_i(lock), .ready_i(ready),
    .resp_i(resp), .trans_i(trans), .burst_i(burst), .release_i(rel),
    .grant_o(grant), .master_o(master), .mastlock_o(mlock)
  );

  typedef struct packed {
    logic [N-1:0] req;
    logic [N-1:0] exp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{5'b00000, 5'b00010},
    '{5'b01100, 5'b00100},
    '{5'b11000, 5'b01000},
    '{5'b10000, 5'b10000},
    '{5'b11110, 5'b00010},
    '{5'b00000, 5'b00010},
    '{5'b10001, 5'b10000}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    req = '0; lock = '0; rel = '0; ready = 1'b1;
    resp = 2'd0; trans = 2'd0; burst = 3'd0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 grant in reset", 32'(grant), 32'b00010);
    chk("R1 master in reset", 32'(master), 32'd1);
    chk("R1 mastlock in reset", 32'(mlock), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic split_one(int m);
    req = N'(1) << m; resp = 2'd0; ready = 1'b1;
    repeat (3) tick();
    resp = 2'd3; ready = 1'b0; tick();
    resp = 2'd3; ready = 1'b1; tick();
    resp = 2'd0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R2 R3 priority table
    foreach (VECS[i]) begin
      req = VECS[i].req;
      tick();
      chk($sformatf("R2/R3 vector %0d", i), 32'(grant), 32'(VECS[i].exp));
    end

    // R4 owner update gated by ready
    do_reset();
    req = 5'b01000; ready = 1'b0; tick();
    chk("R4 master held while not ready", 32'(master), 32'd1);
    ready = 1'b1; lock = 5'b01000; tick();
    chk("R4 master captured", 32'(master), 32'd3);
    chk("R4 mastlock captured", 32'(mlock), 32'd1);

    // R11 defined burst holds grant, INCR does not
    do_reset();
    req = 5'b01000; tick();
    trans = 2'd2; burst = 3'd3; tick();
    chk("R11 owner at burst start", 32'(grant), 32'b01000);
    req = 5'b01010; trans = 2'd3; tick();
    chk("R11 hold beat 2", 32'(grant), 32'b01000);
    ready = 1'b0; tick();
    chk("R11 hold in wait state", 32'(grant), 32'b01000);
    ready = 1'b1; tick();
    chk("R11 hold beat 3", 32'(grant), 32'b01000);
    tick();
    chk("R11 hold beat 4", 32'(grant), 32'b01000);
    trans = 2'd0; tick();
    chk("R11 released after count", 32'(grant), 32'b00010);
    req = 5'b01000; tick();
    trans = 2'd2; burst = 3'd1; tick();
    req = 5'b01010; trans = 2'd3; tick();
    chk("R11 INCR re-arbitrated", 32'(grant), 32'b00010);

    // R5 R6 split masking and release
    do_reset();
    req = 5'b01000; repeat (2) tick();
    trans = 2'd2; tick();
    trans = 2'd0; req = 5'b11000; resp = 2'd3; ready = 1'b0; tick();
    chk("R5 split master masked", 32'(grant), 32'b10000);
    ready = 1'b1; tick();
    resp = 2'd0; req = 5'b01000; tick();
    chk("R5 masked sole requester ignored", 32'(grant), 32'b00010);
    rel = 5'b01000; tick();
    chk("R6 release same cycle", 32'(grant), 32'b01000);
    rel = 5'b00000; tick();
    chk("R6 stays unmasked after pulse", 32'(grant), 32'b01000);

    // R7 split of a locked transfer
    do_reset();
    req = 5'b01000; lock = 5'b01000; repeat (3) tick();
    req = 5'b11000; resp = 2'd3; ready = 1'b0; tick();
    chk("R7 dummy on locked split", 32'(grant), 32'b00001);
    resp = 2'd0; ready = 1'b1; lock = '0;

    // R8 all real masters split
    do_reset();
    for (int m = 1; m < N; m++) split_one(m);
    req = '0; tick();
    chk("R8 dummy when all split", 32'(grant), 32'b00001);
    rel = 5'b00100; tick();
    chk("R3 default masked parks on dummy", 32'(grant), 32'b00001);
    rel = '0; req = 5'b00100; tick();
    chk("R6 released master granted", 32'(grant), 32'b00100);

    // R9 lock hold and unlocked tail
    do_reset();
    req = 5'b01000; lock = 5'b01000; repeat (2) tick();
    req = 5'b01010; tick();
    chk("R9 held while locked", 32'(grant), 32'b01000);
    lock = '0; tick();
    chk("R9 tail transfer kept", 32'(grant), 32'b01000);
    chk("R9 tail mastlock low", 32'(mlock), 32'd0);
    tick();
    chk("R9 handover after tail", 32'(grant), 32'b00010);

    // R10 retry on the last locked transfer
    do_reset();
    req = 5'b01000; lock = 5'b01000; repeat (3) tick();
    lock = '0; req = 5'b01010; tick();
    resp = 2'd2; ready = 1'b0; tick();
    chk("R10 retry keeps locked master", 32'(grant), 32'b01000);
    ready = 1'b1; tick();
    resp = 2'd0;
    chk("R10 handover after retry", 32'(grant), 32'b00010);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule